// File: doc/BRIEF.md
# Programmable Periodic Interrupt Timer

This block is a 16-bit down-counter with three halfword registers on a simple synchronous read/write port. The control register sits at byte offset 0, the modulus register at offset 2, and the live counter at offset 4. The counter moves one step for every 2 x 2^P system clocks, where P is the 4-bit prescale field of the control register.

When the counter is at zero and the next count arrives, the counter reloads and an event flag is set. A level interrupt output follows that flag while the interrupt-enable bit is set. Software clears the flag by writing 1 to it.

The reload value depends on the mode. In reload mode it is the modulus register. In free-running mode it is 0xFFFF. An overwrite option makes a modulus write load the counter at once. A control write that changes only the interrupt enable leaves the counting phase untouched. Any other control write restarts the prescaler. The debug and doze bits are stored and read back but have no effect.

Top module: `pit_timer`

## Requirements
- R1: After reset, the control register (offset 0) and the modulus register (offset 2) read 0x0000, the counter (offset 4) reads 0xFFFF and irqOut is 0.
- R2: The control register fields are: enable at bit 0, reload mode at bit 1, event flag at bit 2, interrupt enable at bit 3, overwrite at bit 4, debug at bit 5, doze at bit 6 and prescale P at bits 11:8. While enable is 1, the counter takes one count every 2 x 2^P system clocks, timed from the control write that started it.
- R3: irqOut is 1 exactly when both the event flag (bit 2) and the interrupt enable (bit 3) are 1.
- R4: Writing 1 to control bit 2 clears the event flag, and writing 0 to it leaves the flag unchanged. The flag is set only by counter expiry, never by software.
- R5: A control write that differs from the stored value only in bit 3 (bit 2 aside) updates the register without disturbing the prescaler phase.
- R6: Any other control write clears the prescaler phase, so that the next count comes a full period after the write. While enable is 0 the counter holds its value.
- R7: A write to the modulus register clears the event flag.
- R8: In reload mode (bit 1 = 1), a count taken at zero loads the modulus value and sets the event flag.
- R9: In free-running mode (bit 1 = 0), a count taken at zero loads 0xFFFF and sets the event flag.
- R10: With overwrite (bit 4) set, a modulus write loads the written value into the counter at once, in either mode. With overwrite clear, a modulus write leaves the counter unchanged.
- R11: Writes to offset 4 change no register.
- R12: Reading offset 4 returns the live counter value as it counts down.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| wrEn | input | 1 | Write strobe for the addressed register |
| addr | input | 3 | Byte offset: 0 control, 2 modulus, 4 counter |
| wrData | input | 16 | Write data |
| rdData | output | 16 | Read data for addr, combinational |
| irqOut | output | 1 | Level interrupt |

## Verification
The bench counts clock edges from each control write, to the edge, and checks the cycle on which every count lands. A design that restarted the prescaler on an enable-only write would be one cycle late on the next count. A design that failed to restart it on a prescale change would be one cycle early.

The zero crossing is checked in both modes. A wrong reload value, or a flag set one count early, shows up in the counter and flag readback. Writing 0 to the flag bit while the flag is set catches a design that treats the bit as plain storage. The modulus and counter writes are checked with overwrite set and with it clear.

// File: rtl/pit_pkg.sv
package pit_pkg;
  parameter int CNT_W = 16;
  parameter int PRE_W = 4;
  localparam int DIV_W = (1 << PRE_W) + 1;

  localparam int BIT_EN   = 0;
  localparam int BIT_RLD  = 1;
  localparam int BIT_FLAG = 2;
  localparam int BIT_IE   = 3;
  localparam int BIT_OVW  = 4;
  localparam int PRE_LO   = 8;

  typedef struct packed {
    logic             runEn;
    logic             clrDiv;
    logic             loadCnt;
    logic [CNT_W-1:0] loadVal;
    logic [CNT_W-1:0] limit;
    logic [PRE_W-1:0] pre;
  } pit_strobe_t;
endpackage

// File: rtl/pit_datapath.sv
module pit_datapath
  import pit_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  pit_strobe_t      strb,
  output logic [CNT_W-1:0] count,
  output logic             expire
);
  logic [DIV_W-1:0] divCnt;
  logic [DIV_W-1:0] divMax;
  logic             tick;

  // one count every 2 << pre system clocks
  assign divMax = (DIV_W'(2) << strb.pre) - DIV_W'(1);
  assign tick   = strb.runEn && (divCnt == divMax);
  assign expire = tick && (count == '0) && !strb.loadCnt;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      divCnt <= '0;
    end else if (strb.clrDiv || !strb.runEn || tick) begin
      divCnt <= '0;
    end else begin
      divCnt <= divCnt + DIV_W'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      count <= '1;
    end else if (strb.loadCnt) begin
      count <= strb.loadVal;
    end else if (tick) begin
      if (count == '0) count <= strb.limit;
      else             count <= count - CNT_W'(1);
    end
  end
endmodule

// File: rtl/pit_ctrl.sv
module pit_ctrl
  import pit_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             wrEn,
  input  logic [2:0]       addr,
  input  logic [15:0]      wrData,
  input  logic             expire,
  output pit_strobe_t      strb,
  output logic [15:0]      ctrlReg,
  output logic [CNT_W-1:0] modReg,
  output logic             irqOut
);
  logic        wrCtrl;
  logic        wrMod;
  logic        onlyIe;
  logic [15:0] ctrlNext;
  logic [15:0] keepMask;

  assign wrCtrl   = wrEn && (addr == 3'd0);
  assign wrMod    = wrEn && (addr == 3'd2);
  assign keepMask = ~((16'd1 << BIT_IE) | (16'd1 << BIT_FLAG));
  assign onlyIe   = ((ctrlReg ^ wrData) & keepMask) == 16'd0;

  always_comb begin
    ctrlNext = ctrlReg;
    if (wrCtrl) begin
      ctrlNext           = wrData;
      ctrlNext[BIT_FLAG] = ctrlReg[BIT_FLAG] & ~wrData[BIT_FLAG];
    end
    if (wrMod)  ctrlNext[BIT_FLAG] = 1'b0;
    if (expire) ctrlNext[BIT_FLAG] = 1'b1;
  end

  always_comb begin
    strb.runEn   = ctrlReg[BIT_EN];
    strb.clrDiv  = wrCtrl && !onlyIe;
    strb.loadCnt = wrMod && ctrlReg[BIT_OVW];
    strb.loadVal = wrData[CNT_W-1:0];
    strb.limit   = ctrlReg[BIT_RLD] ? modReg : '1;
    strb.pre     = ctrlReg[PRE_LO +: PRE_W];
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      ctrlReg <= '0;
      modReg  <= '0;
      irqOut  <= 1'b0;
    end else begin
      ctrlReg <= ctrlNext;
      irqOut  <= ctrlNext[BIT_FLAG] && ctrlNext[BIT_IE];
      if (wrMod) modReg <= wrData[CNT_W-1:0];
    end
  end
endmodule

// File: rtl/pit_timer.sv
module pit_timer
  import pit_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        wrEn,
  input  logic [2:0]  addr,
  input  logic [15:0] wrData,
  output logic [15:0] rdData,
  output logic        irqOut
);
  pit_strobe_t      strb;
  logic [15:0]      ctrlBits;
  logic [CNT_W-1:0] modBits;
  logic [CNT_W-1:0] cntBits;
  logic             expire;

  pit_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .addr(addr), .wrData(wrData),
    .expire(expire), .strb(strb), .ctrlReg(ctrlBits), .modReg(modBits),
    .irqOut(irqOut)
  );

  pit_datapath u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .count(cntBits), .expire(expire)
  );

  always_comb begin
    case (addr)
      3'd0:    rdData = ctrlBits;
      3'd2:    rdData = 16'(modBits);
      3'd4:    rdData = 16'(cntBits);
      default: rdData = 16'd0;
    endcase
  end
endmodule

// File: rtl/pit_checker.sv
module pit_checker
  import pit_pkg::*;
(
  input logic             clk,
  input logic             rstN,
  input logic             wrEn,
  input logic [2:0]       addr,
  input logic             irqOut,
  input logic             expire,
  input logic [15:0]      ctrlBits,
  input logic [CNT_W-1:0] modBits,
  input logic [CNT_W-1:0] cntBits
);
  AST_FLAG_ON_EXPIRE: assert property (@(posedge clk) disable iff (!rstN)
    expire |=> ctrlBits[BIT_FLAG]); // R8

  AST_IRQ_ON_EXPIRE: assert property (@(posedge clk) disable iff (!rstN)
    (expire && ctrlBits[BIT_IE] && !wrEn) |=> irqOut); // R3

  AST_MOD_WR_CLEARS: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && addr == 3'd2 && !expire) |=> !ctrlBits[BIT_FLAG]); // R7

  AST_STOPPED_HOLDS: assert property (@(posedge clk) disable iff (!rstN)
    (!ctrlBits[BIT_EN] && !(wrEn && addr == 3'd2)) |=> $stable(cntBits)); // R6

  AST_CNT_WR_IGNORED: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && addr == 3'd4 && !ctrlBits[BIT_EN]) |=> $stable(cntBits)); // R11

  AST_RELOAD_VALUE: assert property (@(posedge clk) disable iff (!rstN)
    (expire && !wrEn) |=>
      (cntBits == ($past(ctrlBits[BIT_RLD]) ? $past(modBits) : {CNT_W{1'b1}}))); // R9
endmodule

bind pit_timer pit_checker u_checker (
  .clk(clk), .rstN(rstN), .wrEn(wrEn), .addr(addr), .irqOut(irqOut),
  .expire(expire), .ctrlBits(ctrlBits), .modBits(modBits), .cntBits(cntBits)
);

// File: tb/test_pit_timer.sv
module test_pit_timer;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        wrEn = 1'b0;
  logic [2:0]  addr = 3'd0;
  logic [15:0] wrData = 16'd0;
  logic [15:0] rdData;
  logic        irqOut;
  int          nRun = 0;
  int          nFail = 0;
  logic [15:0] held;

  pit_timer i_pit_timer (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .addr(addr), .wrData(wrData),
    .rdData(rdData), .irqOut(irqOut)
  );

  always #10 clk = ~clk;

  task automatic check(input string tag, input logic [15:0] got, input logic [15:0] exp);
    nRun++;
    if (got !== exp) begin
      nFail++;
      $display("FAIL %s: got 0x%04h expected 0x%04h", tag, got, exp);
    end
  endtask

  // called at a negedge, returns at the negedge after the write edge
  task automatic wr(input logic [2:0] a, input logic [15:0] d);
    addr = a; wrData = d; wrEn = 1'b1;
    @(posedge clk);
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [15:0] d);
    addr = a;
    #1;
    d = rdData;
  endtask

  task automatic edges(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic chkReg(input string tag, input logic [2:0] a, input logic [15:0] exp);
    logic [15:0] v;
    rd(a, v);
    check(tag, v, exp);
  endtask

  task automatic testReset();
    chkReg("R1 ctrl", 3'd0, 16'h0000);
    chkReg("R1 mod", 3'd2, 16'h0000);
    chkReg("R1 count", 3'd4, 16'hFFFF);
    check("R1 irq", {15'd0, irqOut}, 16'd0);
  endtask

  task automatic testFreeRun();
    wr(3'd0, 16'h0010);
    wr(3'd2, 16'd5);
    chkReg("R10 ovw load free", 3'd4, 16'd5);
    wr(3'd0, 16'h0011);
    edges(5);
    chkReg("R12 live count", 3'd4, 16'd3);
    edges(6);
    chkReg("R9 at zero", 3'd4, 16'd0);
    chkReg("R9 flag not early", 3'd0, 16'h0011);
    edges(1);
    chkReg("R9 reload ffff", 3'd4, 16'hFFFF);
    chkReg("R9 flag set", 3'd0, 16'h0015);
    check("R3 irq masked", {15'd0, irqOut}, 16'd0);
  endtask

  task automatic testIrq();
    wr(3'd0, 16'h0019);
    chkReg("R4 ie set keeps flag", 3'd0, 16'h001D);
    check("R3 irq on", {15'd0, irqOut}, 16'd1);
    wr(3'd0, 16'h0019);
    chkReg("R4 zero no effect", 3'd0, 16'h001D);
    wr(3'd0, 16'h001D);
    chkReg("R4 w1c", 3'd0, 16'h0019);
    check("R3 irq off", {15'd0, irqOut}, 16'd0);
  endtask

  task automatic testReload();
    wr(3'd0, 16'h0012);
    wr(3'd2, 16'd3);
    chkReg("R10 ovw load reload", 3'd4, 16'd3);
    wr(3'd0, 16'h0013);
    edges(7);
    chkReg("R8 at zero", 3'd4, 16'd0);
    edges(1);
    chkReg("R8 reload mod", 3'd4, 16'd3);
    chkReg("R8 flag set", 3'd0, 16'h0017);
    wr(3'd2, 16'd7);
    chkReg("R7 mod wr clears flag", 3'd0, 16'h0013);
    chkReg("R10 reload ovw count", 3'd4, 16'd7);
  endtask

  task automatic testNoOvw();
    wr(3'd0, 16'h0002);
    rd(3'd4, held);
    wr(3'd2, 16'd9);
    chkReg("R10 no ovw reload", 3'd4, held);
    chkReg("R10 mod stored", 3'd2, 16'd9);
    wr(3'd0, 16'h0000);
    wr(3'd2, 16'h0020);
    chkReg("R10 no ovw free", 3'd4, held);
    wr(3'd4, 16'h1234);
    chkReg("R11 count kept", 3'd4, held);
    chkReg("R11 ctrl kept", 3'd0, 16'h0000);
    chkReg("R11 mod kept", 3'd2, 16'h0020);
  endtask

  task automatic testPrescale();
    wr(3'd0, 16'h0010);
    wr(3'd2, 16'd100);
    wr(3'd0, 16'h0211);
    edges(7);
    chkReg("R2 before first count", 3'd4, 16'd100);
    edges(1);
    chkReg("R2 first count", 3'd4, 16'd99);
    edges(8);
    chkReg("R2 second count", 3'd4, 16'd98);
    wr(3'd0, 16'h0219);
    chkReg("R5 ie update", 3'd0, 16'h0219);
    edges(6);
    chkReg("R5 not yet", 3'd4, 16'd98);
    edges(1);
    chkReg("R5 phase kept", 3'd4, 16'd97);
    wr(3'd0, 16'h0311);
    edges(15);
    chkReg("R6 phase restarted", 3'd4, 16'd97);
    edges(1);
    chkReg("R6 count after restart", 3'd4, 16'd96);
    wr(3'd0, 16'h0310);
    edges(40);
    chkReg("R6 stopped holds", 3'd4, 16'd96);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    testFreeRun();
    testIrq();
    testReload();
    testNoOvw();
    testPrescale();
    $display("  [TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end

  initial begin
    #2000000;
    nRun++;
    nFail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end
endmodule